// File: doc/BRIEF.md
# DMA Channel Request Qualifier

This block decides which DMA channel a transfer engine should serve next. Every cycle it looks at each channel's configuration word and remaining transfer count. It also looks at the peripheral request lines. From these it works out which channels are ready to move data. The lowest-numbered ready channel wins, and its index is captured in a register together with a valid flag.

A channel is ready when four things hold. The controller as a whole must be switched on. The channel itself must be enabled and not halted. Its transfer count must be nonzero. Finally, the peripherals its flow type depends on must be requesting. The flow type says whether the source peripheral's request, the destination peripheral's request, both of them, or neither is required.

The engine drives a busy input while it works on the granted channel. While busy is high the grant is frozen, so the engine sees a stable index for the whole transfer. Flow types outside the supported set never make a channel ready. Instead they raise a per-channel unsupported-flow flag, so that firmware mistakes become visible.

Top module: `dma_req_qualifier`

## Requirements
- R1: While `globalEn` is 0, `grantValid` is 0 from the next clock edge on. This holds even when `engineBusy` is high.
- R2: A channel can be ready only if its configuration bit 0 (enable) is 1 and bit 18 (halt) is 0.
- R3: Configuration bits 13:11 hold the flow type. Bits 5:1 hold the source peripheral ID, and bits 10:6 hold the destination peripheral ID.
- R4: Flow type 0 (memory to memory) needs no peripheral request.
- R5: Each peripheral flow type needs specific requests:
  - flow type 1 needs the destination peripheral's request;
  - flow type 2 needs the source peripheral's request;
  - flow type 3 needs both requests.
- R6: A peripheral counts as requesting when its bit is set in `reqSingle` or in `reqBurst`. An ID at or above `NUM_PERIPH` never counts as requesting.
- R7: A channel whose 12-bit transfer count is zero is never ready.
- R8: When several channels are ready, the lowest index is granted.
- R9: Flow types 4 to 7 never make a channel ready. For an enabled, non-halted channel with such a type, its `flowErr` bit reads 1 one cycle later. Otherwise that bit reads 0.
- R10: The grant behaves as follows:
  - It is registered, so inputs seen at one clock edge appear after that edge.
  - It holds its value while `engineBusy` is high.
  - When no channel is ready, `grantValid` is 0 and `grantIdx` is 0.
  - After reset, `grantValid`, `grantIdx` and `flowErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Controller-wide enable |
| chanCfg | input | NUM_CH*32 | Configuration word of each channel, channel c at bits c*32 upward |
| chanCount | input | NUM_CH*12 | Remaining transfer count of each channel |
| reqSingle | input | NUM_PERIPH | Single-transfer request from each peripheral |
| reqBurst | input | NUM_PERIPH | Burst request from each peripheral |
| engineBusy | input | 1 | Engine is working on the current grant; freezes the grant |
| grantValid | output | 1 | A channel is granted |
| grantIdx | output | $clog2(NUM_CH) | Index of the granted channel |
| flowErr | output | NUM_CH | Per-channel unsupported flow type flag |

## Verification
Each flow type is tried with several request patterns:
- no request at all;
- only the source request;
- only the destination request;
- both requests.

This shows which peripheral each type depends on. Separate IDs are placed high in both ID fields, so a swapped or shifted field shows up. Requests arrive on the single lines alone and on the burst lines alone, which confirms that either source is enough. Sets of several ready channels are applied, with the lowest one then withdrawn, to show priority order. A different channel becomes ready while busy is high, which separates a frozen grant from one that follows its inputs.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int CFG_W        = 32;
  localparam int CNT_W        = 12;
  localparam int PID_W        = 5;
  localparam int FLOW_W       = 3;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_SRC_LSB  = 1;
  localparam int CFG_DST_LSB  = 6;
  localparam int CFG_FLOW_LSB = 11;
  localparam int CFG_HALT_BIT = 18;
  localparam int PID_SPAN     = 1 << PID_W;

  localparam logic [FLOW_W-1:0] FLOW_MEM2MEM = 3'd0;
  localparam logic [FLOW_W-1:0] FLOW_TO_DST  = 3'd1;
  localparam logic [FLOW_W-1:0] FLOW_FROM_SRC = 3'd2;
  localparam logic [FLOW_W-1:0] FLOW_PER2PER = 3'd3;

  typedef struct packed {
    logic clearGrant;
    logic loadGrant;
    logic holdGrant;
  } grantStrobes_t;
endpackage

// File: rtl/dmaq_chan_eval.sv
module dmaq_chan_eval
  import dmaq_pkg::*;
#(
  parameter int NUM_PERIPH = 32
) (
  input  logic [CFG_W-1:0]      cfg,
  input  logic [CNT_W-1:0]      count,
  input  logic [NUM_PERIPH-1:0] req,
  output logic                  eligible,
  output logic                  badFlow
);
  logic [PID_SPAN-1:0] reqExt;
  logic [PID_W-1:0]    srcId;
  logic [PID_W-1:0]    dstId;
  logic [FLOW_W-1:0]   flowType;
  logic                candidate;
  logic                srcReq;
  logic                dstReq;
  logic                flowOk;
  logic                flowUnsupported;

  // Peripheral IDs beyond NUM_PERIPH read as not requesting (R6)
  always_comb begin
    reqExt = '0;
    reqExt[NUM_PERIPH-1:0] = req;
  end

  // Field extraction (R3)
  assign srcId     = cfg[CFG_SRC_LSB +: PID_W];
  assign dstId     = cfg[CFG_DST_LSB +: PID_W];
  assign flowType  = cfg[CFG_FLOW_LSB +: FLOW_W];
  assign candidate = cfg[CFG_EN_BIT] & ~cfg[CFG_HALT_BIT];
  assign srcReq    = reqExt[srcId];
  assign dstReq    = reqExt[dstId];

  // Flow-type gating (R4, R5, R9)
  always_comb begin
    flowOk = 1'b0;
    flowUnsupported = 1'b0;
    unique case (flowType)
      FLOW_MEM2MEM:  flowOk = 1'b1;
      FLOW_TO_DST:   flowOk = dstReq;
      FLOW_FROM_SRC: flowOk = srcReq;
      FLOW_PER2PER:  flowOk = srcReq & dstReq;
      default:       flowUnsupported = 1'b1;
    endcase
  end

  assign eligible = candidate & (count != '0) & flowOk;
  assign badFlow  = candidate & flowUnsupported;
endmodule

// File: rtl/dmaq_control.sv
module dmaq_control
  import dmaq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          globalEn,
  input  logic          engineBusy,
  output grantStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    if (!globalEn)       strobes.clearGrant = 1'b1;
    else if (engineBusy) strobes.holdGrant  = 1'b1;
    else                 strobes.loadGrant  = 1'b1;
  end

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobes) == 1)
    else $error("a_r10_one_strobe");

  a_r1_clear_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> strobes.clearGrant && !strobes.loadGrant)
    else $error("a_r1_clear_when_off");
endmodule

// File: rtl/dmaq_datapath.sv
module dmaq_datapath
  import dmaq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int NUM_PERIPH = 32,
  localparam int IDX_W     = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH*CFG_W-1:0] chanCfg,
  input  logic [NUM_CH*CNT_W-1:0] chanCount,
  input  logic [NUM_PERIPH-1:0]   reqSingle,
  input  logic [NUM_PERIPH-1:0]   reqBurst,
  input  grantStrobes_t           strobes,
  output logic                    grantValid,
  output logic [IDX_W-1:0]        grantIdx,
  output logic [NUM_CH-1:0]       flowErr
);
  logic [NUM_PERIPH-1:0] reqAny;
  logic [NUM_CH-1:0]     eligVec;
  logic [NUM_CH-1:0]     badVec;
  logic [IDX_W-1:0]      pickIdx;
  logic                  anyElig;

  // Either request line flags a peripheral (R6)
  assign reqAny = reqSingle | reqBurst;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dmaq_chan_eval #(.NUM_PERIPH(NUM_PERIPH)) u_eval (
      .cfg      (chanCfg[c*CFG_W +: CFG_W]),
      .count    (chanCount[c*CNT_W +: CNT_W]),
      .req      (reqAny),
      .eligible (eligVec[c]),
      .badFlow  (badVec[c])
    );

    a_r7_zero_count: assert property (@(posedge clk) disable iff (!rstN)
      (chanCount[c*CNT_W +: CNT_W] == '0) |-> !eligVec[c])
      else $error("a_r7_zero_count");

    a_r2_halted_idle: assert property (@(posedge clk) disable iff (!rstN)
      chanCfg[c*CFG_W + CFG_HALT_BIT] |-> !eligVec[c])
      else $error("a_r2_halted_idle");
  end

  // Fixed priority, lowest index first (R8)
  always_comb begin
    pickIdx = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (eligVec[c]) pickIdx = IDX_W'(c);
    end
  end
  assign anyElig = |eligVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantIdx   <= '0;
      flowErr    <= '0;
    end else begin
      flowErr <= badVec;
      if (strobes.clearGrant) begin
        grantValid <= 1'b0;
        grantIdx   <= '0;
      end else if (strobes.loadGrant) begin
        grantValid <= anyElig;
        grantIdx   <= pickIdx;
      end
    end
  end

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdGrant |=> $stable(grantIdx) && $stable(grantValid))
    else $error("a_r10_hold_stable");

  a_r8_chan0_first: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadGrant && eligVec[0] |=> grantValid && grantIdx == '0)
    else $error("a_r8_chan0_first");

  a_r9_bad_not_elig: assert property (@(posedge clk) disable iff (!rstN)
    (badVec & eligVec) == '0)
    else $error("a_r9_bad_not_elig");
endmodule

// File: rtl/dma_req_qualifier.sv
module dma_req_qualifier
  import dmaq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int NUM_PERIPH = 32,
  localparam int IDX_W     = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    globalEn,
  input  logic [NUM_CH*CFG_W-1:0] chanCfg,
  input  logic [NUM_CH*CNT_W-1:0] chanCount,
  input  logic [NUM_PERIPH-1:0]   reqSingle,
  input  logic [NUM_PERIPH-1:0]   reqBurst,
  input  logic                    engineBusy,
  output logic                    grantValid,
  output logic [IDX_W-1:0]        grantIdx,
  output logic [NUM_CH-1:0]       flowErr
);
  grantStrobes_t strobes;

  dmaq_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .globalEn   (globalEn),
    .engineBusy (engineBusy),
    .strobes    (strobes)
  );

  dmaq_datapath #(.NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .chanCfg    (chanCfg),
    .chanCount  (chanCount),
    .reqSingle  (reqSingle),
    .reqBurst   (reqBurst),
    .strobes    (strobes),
    .grantValid (grantValid),
    .grantIdx   (grantIdx),
    .flowErr    (flowErr)
  );

  a_r1_disabled_no_grant: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> !grantValid)
    else $error("a_r1_disabled_no_grant");
endmodule

// File: tb/dma_req_qualifier_test.sv
module dma_req_qualifier_test;
  localparam int NUM_CH = 8;
  localparam int NUM_PERIPH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalEn = 1'b0;
  logic [NUM_CH*32-1:0] chanCfg = '0;
  logic [NUM_CH*12-1:0] chanCount = '0;
  logic [NUM_PERIPH-1:0] reqSingle = '0;
  logic [NUM_PERIPH-1:0] reqBurst = '0;
  logic engineBusy = 1'b0;
  logic grantValid;
  logic [2:0] grantIdx;
  logic [NUM_CH-1:0] flowErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_req_qualifier #(.NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH)) uut (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .chanCfg(chanCfg),
    .chanCount(chanCount), .reqSingle(reqSingle), .reqBurst(reqBurst),
    .engineBusy(engineBusy), .grantValid(grantValid), .grantIdx(grantIdx),
    .flowErr(flowErr)
  );

  // Config word: en bit0, src 5:1, dst 10:6, flow 13:11, halt bit18
  function automatic logic [31:0] mkCfg(bit en, bit halt, int flow, int src, int dst);
    logic [31:0] w = '0;
    w[0] = en;
    w[5:1] = src[4:0];
    w[10:6] = dst[4:0];
    w[13:11] = flow[2:0];
    w[18] = halt;
    return w;
  endfunction

  task automatic setChan(int c, logic [31:0] cfg, int cnt);
    chanCfg[c*32 +: 32] = cfg;
    chanCount[c*12 +: 12] = cnt[11:0];
  endtask

  task automatic clearAll();
    chanCfg = '0;
    chanCount = '0;
    reqSingle = '0;
    reqBurst = '0;
    engineBusy = 1'b0;
    globalEn = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expectGrant(string tag, bit expV, int expIdx);
    checks++;
    if (grantValid !== expV || (expV && grantIdx !== expIdx[2:0])) begin
      errors++;
      $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d",
               tag, grantValid, grantIdx, expV, expIdx);
    end
  endtask

  task automatic expectErr(string tag, logic [NUM_CH-1:0] exp);
    checks++;
    if (flowErr !== exp) begin
      errors++;
      $display("FAIL %s: flowErr=%b expected %b", tag, flowErr, exp);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    globalEn = 1'b1;
    setChan(0, mkCfg(1, 0, 0, 0, 0), 3);
    tick(); tick();
    expectGrant("R10 reset", 0, 0);
    checks++;
    if (grantIdx !== 3'd0) begin
      errors++;
      $display("FAIL R10 reset idx: %0d expected 0", grantIdx);
    end
    expectErr("R10 reset flowErr", '0);
    rstN = 1'b1;
  endtask

  task automatic t_global();
    clearAll();
    globalEn = 1'b0;
    setChan(2, mkCfg(1, 0, 0, 0, 0), 5);
    tick();
    expectGrant("R1 disabled", 0, 0);
    globalEn = 1'b1;
    tick();
    expectGrant("R1 enabled", 1, 2);
    engineBusy = 1'b1;
    globalEn = 1'b0;
    tick();
    expectGrant("R1 disabled while busy", 0, 0);
  endtask

  task automatic t_enableHalt();
    clearAll();
    setChan(1, mkCfg(0, 0, 0, 0, 0), 4);
    tick();
    expectGrant("R2 channel disabled", 0, 0);
    setChan(1, mkCfg(1, 1, 0, 0, 0), 4);
    tick();
    expectGrant("R2 channel halted", 0, 0);
    setChan(1, mkCfg(1, 0, 0, 0, 0), 4);
    tick();
    expectGrant("R2 enabled not halted", 1, 1);
  endtask

  task automatic t_flows();
    clearAll();
    setChan(0, mkCfg(1, 0, 0, 3, 7), 2);
    tick();
    expectGrant("R4 mem2mem no request", 1, 0);
    setChan(0, mkCfg(1, 0, 1, 3, 7), 2);
    reqSingle[3] = 1'b1;
    tick();
    expectGrant("R5 flow1 source only", 0, 0);
    reqSingle = '0; reqSingle[7] = 1'b1;
    tick();
    expectGrant("R5 flow1 dest", 1, 0);
    setChan(0, mkCfg(1, 0, 2, 3, 7), 2);
    tick();
    expectGrant("R5 flow2 dest only", 0, 0);
    reqSingle = '0; reqSingle[3] = 1'b1;
    tick();
    expectGrant("R5 flow2 source", 1, 0);
    setChan(0, mkCfg(1, 0, 3, 3, 7), 2);
    tick();
    expectGrant("R5 flow3 source only", 0, 0);
    reqSingle[7] = 1'b1;
    tick();
    expectGrant("R5 flow3 both", 1, 0);
  endtask

  task automatic t_fields();
    clearAll();
    setChan(6, mkCfg(1, 0, 3, 9, 20), 1);
    reqSingle[9] = 1'b1; reqSingle[20] = 1'b1;
    tick();
    expectGrant("R3 high ids both", 1, 6);
    reqSingle = '0; reqSingle[20] = 1'b1; reqSingle[5] = 1'b1;
    tick();
    expectGrant("R3 wrong source bit", 0, 0);
  endtask

  task automatic t_reqOr();
    clearAll();
    setChan(3, mkCfg(1, 0, 1, 0, 12), 6);
    reqBurst[12] = 1'b1;
    tick();
    expectGrant("R6 burst only", 1, 3);
    reqBurst = '0; reqSingle[12] = 1'b1;
    tick();
    expectGrant("R6 single only", 1, 3);
    reqSingle = '0;
    tick();
    expectGrant("R6 none", 0, 0);
  endtask

  task automatic t_count();
    clearAll();
    setChan(5, mkCfg(1, 0, 0, 0, 0), 0);
    tick();
    expectGrant("R7 zero count", 0, 0);
    setChan(5, mkCfg(1, 0, 0, 0, 0), 4095);
    tick();
    expectGrant("R7 full count", 1, 5);
  endtask

  task automatic t_priority();
    clearAll();
    setChan(6, mkCfg(1, 0, 0, 0, 0), 1);
    setChan(5, mkCfg(1, 0, 0, 0, 0), 1);
    setChan(3, mkCfg(1, 0, 0, 0, 0), 1);
    tick();
    expectGrant("R8 lowest of 3,5,6", 1, 3);
    setChan(3, mkCfg(1, 0, 0, 0, 0), 0);
    tick();
    expectGrant("R8 lowest of 5,6", 1, 5);
    setChan(0, mkCfg(1, 0, 0, 0, 0), 1);
    tick();
    expectGrant("R8 channel 0", 1, 0);
  endtask

  task automatic t_badFlow();
    clearAll();
    setChan(1, mkCfg(1, 0, 5, 0, 0), 3);
    setChan(4, mkCfg(1, 1, 7, 0, 0), 3);
    reqSingle = '1;
    tick();
    expectGrant("R9 unsupported flow", 0, 0);
    expectErr("R9 flag", 8'b0000_0010);
    setChan(4, mkCfg(1, 0, 7, 0, 0), 3);
    setChan(1, mkCfg(1, 0, 4, 0, 0), 3);
    setChan(2, mkCfg(1, 0, 0, 0, 0), 3);
    tick();
    expectGrant("R9 other channel wins", 1, 2);
    expectErr("R9 flags 1,4", 8'b0001_0010);
  endtask

  task automatic t_busy();
    clearAll();
    setChan(4, mkCfg(1, 0, 0, 0, 0), 2);
    tick();
    expectGrant("R10 grant 4", 1, 4);
    engineBusy = 1'b1;
    setChan(1, mkCfg(1, 0, 0, 0, 0), 2);
    tick();
    expectGrant("R10 held while busy", 1, 4);
    setChan(4, mkCfg(0, 0, 0, 0, 0), 2);
    setChan(1, mkCfg(0, 0, 0, 0, 0), 2);
    tick();
    expectGrant("R10 held with none ready", 1, 4);
    engineBusy = 1'b0;
    setChan(1, mkCfg(1, 0, 0, 0, 0), 2);
    tick();
    expectGrant("R10 released", 1, 1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1;
    t_reset();
    t_global();
    t_enableHalt();
    t_flows();
    t_fields();
    t_reqOr();
    t_count();
    t_priority();
    t_badFlow();
    t_busy();
    finish();
  end

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish();
  end
endmodule